// File: doc/BRIEF.md
# Stack Pointer and Stack Access Engine

This block owns the stack pointer of a small byte-oriented processor and performs all stack traffic on its behalf. The core hands it one of four requests: push a data byte, pop a data byte, save a 16-bit return address (subroutine call or interrupt entry), or restore one (return). The engine turns each request into accesses on a byte-wide synchronous data-memory port, moves the pointer by the right step, and returns popped bytes or restored addresses to the core.

The stack grows toward lower addresses and the pointer always names the next free location. Software sees the pointer as two byte-wide read/write registers, one for the upper byte and one for the lower. A status pulse marks any stack access that lands in the low page reserved for registers and I/O, which is never a valid stack area.

Top module: `stk_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the pointer reads 0x0000, `busy` is low, `mem_en` is low and neither response valid is high.
- R2: An accepted byte push (`req_op` = 0) writes `req_byte` at the current pointer in the cycle after acceptance and lowers the pointer by one; `busy` stays low.
- R3: An accepted byte pop (`req_op` = 1) raises the pointer by one, reads at the new pointer in the cycle after acceptance, and pulses `rsp_byte_vld` with that byte two cycles after the read cycle.
- R4: An accepted address push (`req_op` = 2) writes `req_ret[7:0]` at the pointer P, then in the following cycle `req_ret[15:8]` at P-1; the pointer ends at P-2 and `busy` is high for exactly the cycle between the two writes.
- R5: An accepted address pop (`req_op` = 3) from pointer P reads P+1 (upper byte) and then P+2 (lower byte) on consecutive cycles, ends with the pointer at P+2, and pulses `rsp_addr_vld` with the rebuilt address two cycles after the second read.
- R6: `spr_wr_hi` loads `spr_wdata` into pointer bits 15:8 and `spr_wr_lo` into bits 7:0, each leaving the other byte unchanged; both may be written in one cycle; `spr_hi`/`spr_lo` show the pointer bytes.
- R7: A request presented in the same cycle as either software pointer write is dropped: no memory access results and the pointer takes the software value.
- R8: A request presented while `busy` is high is dropped and causes no memory access.
- R9: `low_fault` is high together with `mem_en` exactly when `mem_addr` is at or below 0x00FF.
- R10: Byte pushes and byte pops are accepted on consecutive cycles, one memory access per cycle, with responses returned in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Stack request strobe |
| req_op | input | 2 | 0 byte push, 1 byte pop, 2 address push, 3 address pop |
| req_byte | input | 8 | Byte to push |
| req_ret | input | 16 | Return address to push |
| busy | output | 1 | Second beat of a two-byte operation in progress |
| spr_wr_hi | input | 1 | Software write of the pointer upper byte |
| spr_wr_lo | input | 1 | Software write of the pointer lower byte |
| spr_wdata | input | 8 | Software write data |
| spr_hi | output | 8 | Pointer bits 15:8 |
| spr_lo | output | 8 | Pointer bits 7:0 |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read access |
| rsp_byte_vld | output | 1 | Popped byte valid pulse |
| rsp_byte | output | 8 | Popped byte |
| rsp_addr_vld | output | 1 | Restored address valid pulse |
| rsp_addr | output | 16 | Restored address |
| low_fault | output | 1 | Current access targets 0x00FF or below |

## Verification
Two pairs of events can share a cycle: a stack request with a software write of a pointer byte, and a new request with the second beat of a call or return. The bench raises a push together with a lower-byte write and expects no memory access and the software value in the pointer; it then places a push in the busy cycle of an address push and expects only the upper-byte write followed by an idle port and a pointer two below its start. Random mixes of all four operations around these cases are compared against a bench-side pointer and shadow memory.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_BYTE = 2'd1,
    TAG_HI   = 2'd2,
    TAG_LO   = 2'd3
  } rd_tag_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CALL2 = 2'd1,
    ST_RET2  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_hi,
  input  logic                  wr_lo,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  step_en,
  input  logic                  step_dn,
  output logic [2*DATA_W-1:0]   sp
);
  localparam int AW = 2 * DATA_W;

  // software byte writes take precedence over any step
  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (wr_hi || wr_lo) begin
      if (wr_hi) sp[AW-1:DATA_W] <= wdata;
      if (wr_lo) sp[DATA_W-1:0]  <= wdata;
    end else if (step_en) begin
      sp <= step_dn ? sp - AW'(1) : sp + AW'(1);
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOW_LIMIT = 255
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [1:0]            req_op,
  input  logic [DATA_W-1:0]     req_byte,
  input  logic [2*DATA_W-1:0]   req_ret,
  input  logic                  sw_wr,
  input  logic [2*DATA_W-1:0]   sp,
  output logic                  busy,
  output logic                  step_en,
  output logic                  step_dn,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [2*DATA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [1:0]            mem_tag,
  output logic                  low_fault
);
  localparam int AW = 2 * DATA_W;

  seq_st_e           st, st_n;
  logic [DATA_W-1:0] hold, hold_n;
  stk_op_e           op;
  logic              accept;
  logic              issue, we_n;
  logic [AW-1:0]     addr_n;
  logic [DATA_W-1:0] wd_n;
  rd_tag_e           tag_n;

  assign op     = stk_op_e'(req_op);
  assign accept = req_valid && (st == ST_IDLE) && !sw_wr;
  assign busy   = (st != ST_IDLE);

  always_comb begin
    st_n    = st;
    hold_n  = hold;
    issue   = 1'b0;
    we_n    = 1'b0;
    addr_n  = sp;
    wd_n    = '0;
    tag_n   = TAG_NONE;
    step_en = 1'b0;
    step_dn = 1'b0;
    case (st)
      ST_IDLE: begin
        if (accept) begin
          issue   = 1'b1;
          step_en = 1'b1;
          case (op)
            OP_PUSH: begin
              we_n    = 1'b1;
              wd_n    = req_byte;
              step_dn = 1'b1;
            end
            OP_POP: begin
              addr_n = sp + AW'(1);
              tag_n  = TAG_BYTE;
            end
            OP_CALL: begin
              we_n    = 1'b1;
              wd_n    = req_ret[DATA_W-1:0];
              step_dn = 1'b1;
              hold_n  = req_ret[AW-1:DATA_W];
              st_n    = ST_CALL2;
            end
            OP_RET: begin
              addr_n = sp + AW'(1);
              tag_n  = TAG_HI;
              st_n   = ST_RET2;
            end
            default: ;
          endcase
        end
      end
      ST_CALL2: begin
        issue   = 1'b1;
        we_n    = 1'b1;
        wd_n    = hold;
        step_en = 1'b1;
        step_dn = 1'b1;
        st_n    = ST_IDLE;
      end
      ST_RET2: begin
        issue   = 1'b1;
        addr_n  = sp + AW'(1);
        tag_n   = TAG_LO;
        step_en = 1'b1;
        st_n    = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      hold      <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_tag   <= TAG_NONE;
      low_fault <= 1'b0;
    end else begin
      st        <= st_n;
      hold      <= hold_n;
      mem_en    <= issue;
      mem_we    <= issue && we_n;
      mem_addr  <= addr_n;
      mem_wdata <= wd_n;
      mem_tag   <= issue ? tag_n : TAG_NONE;
      low_fault <= issue && (addr_n <= AW'(LOW_LIMIT));
    end
  end
endmodule

// File: rtl/stk_rdret.sv
module stk_rdret
  import stk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            mem_tag,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  byte_vld,
  output logic [DATA_W-1:0]     byte_q,
  output logic                  addr_vld,
  output logic [2*DATA_W-1:0]   addr_q
);
  rd_tag_e           tag_q;
  logic [DATA_W-1:0] hi_q;

  // tag follows the access by one cycle so it lines up with mem_rdata
  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q    <= TAG_NONE;
      hi_q     <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      addr_vld <= 1'b0;
      addr_q   <= '0;
    end else begin
      tag_q    <= rd_tag_e'(mem_tag);
      byte_vld <= (tag_q == TAG_BYTE);
      addr_vld <= (tag_q == TAG_LO);
      if (tag_q == TAG_BYTE) byte_q <= mem_rdata;
      if (tag_q == TAG_HI)   hi_q   <= mem_rdata;
      if (tag_q == TAG_LO)   addr_q <= {hi_q, mem_rdata};
    end
  end
endmodule

// File: rtl/stk_engine.sv
module stk_engine #(
  parameter int DATA_W    = 8,
  parameter int LOW_LIMIT = 255
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [1:0]            req_op,
  input  logic [DATA_W-1:0]     req_byte,
  input  logic [2*DATA_W-1:0]   req_ret,
  output logic                  busy,
  input  logic                  spr_wr_hi,
  input  logic                  spr_wr_lo,
  input  logic [DATA_W-1:0]     spr_wdata,
  output logic [DATA_W-1:0]     spr_hi,
  output logic [DATA_W-1:0]     spr_lo,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [2*DATA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  rsp_byte_vld,
  output logic [DATA_W-1:0]     rsp_byte,
  output logic                  rsp_addr_vld,
  output logic [2*DATA_W-1:0]   rsp_addr,
  output logic                  low_fault
);
  localparam int AW = 2 * DATA_W;

  logic [AW-1:0] sp;
  logic          step_en, step_dn;
  logic [1:0]    mem_tag;

  assign spr_hi = sp[AW-1:DATA_W];
  assign spr_lo = sp[DATA_W-1:0];

  stk_ptr #(.DATA_W(DATA_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .wr_hi   (spr_wr_hi),
    .wr_lo   (spr_wr_lo),
    .wdata   (spr_wdata),
    .step_en (step_en),
    .step_dn (step_dn),
    .sp      (sp)
  );

  stk_seq #(.DATA_W(DATA_W), .LOW_LIMIT(LOW_LIMIT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_byte  (req_byte),
    .req_ret   (req_ret),
    .sw_wr     (spr_wr_hi || spr_wr_lo),
    .sp        (sp),
    .busy      (busy),
    .step_en   (step_en),
    .step_dn   (step_dn),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_tag   (mem_tag),
    .low_fault (low_fault)
  );

  stk_rdret #(.DATA_W(DATA_W)) u_rdret (
    .clk       (clk),
    .rst       (rst),
    .mem_tag   (mem_tag),
    .mem_rdata (mem_rdata),
    .byte_vld  (rsp_byte_vld),
    .byte_q    (rsp_byte),
    .addr_vld  (rsp_addr_vld),
    .addr_q    (rsp_addr)
  );
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk
  import stk_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LOW_LIMIT = 255
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic [1:0]            req_op,
  input logic                  busy,
  input logic                  spr_wr_hi,
  input logic                  spr_wr_lo,
  input logic [DATA_W-1:0]     spr_wdata,
  input logic [DATA_W-1:0]     spr_hi,
  input logic [DATA_W-1:0]     spr_lo,
  input logic                  mem_en,
  input logic [2*DATA_W-1:0]   mem_addr,
  input logic                  rsp_byte_vld,
  input logic                  rsp_addr_vld,
  input logic                  low_fault
);
  localparam int AW = 2 * DATA_W;

  logic [AW-1:0] sp;
  logic          sw, acc;
  assign sp  = {spr_hi, spr_lo};
  assign sw  = spr_wr_hi || spr_wr_lo;
  assign acc = !rst && req_valid && !busy && !sw;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sp == '0) && !busy && !mem_en && !rsp_byte_vld && !rsp_addr_vld);

  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == OP_PUSH) |=> sp == $past(sp) - AW'(1));

  p_pop_step_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == OP_POP) |=> sp == $past(sp) + AW'(1));

  p_call_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == OP_CALL) |=> busy);

  p_call_step_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(acc && req_op == OP_CALL, 2) && !$past(sw)) |-> sp == $past(sp, 2) - AW'(2));

  p_ret_step_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(acc && req_op == OP_RET, 2) && !$past(sw)) |-> sp == $past(sp, 2) + AW'(2));

  p_sw_hi_r6: assert property (@(posedge clk) disable iff (rst)
    spr_wr_hi |=> spr_hi == $past(spr_wdata));

  p_sw_lo_r6: assert property (@(posedge clk) disable iff (rst)
    spr_wr_lo |=> spr_lo == $past(spr_wdata));

  p_sw_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sw && !busy) |=> !mem_en);

  p_busy_single_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  p_fault_addr_r9: assert property (@(posedge clk) disable iff (rst)
    low_fault |-> mem_en && (mem_addr <= AW'(LOW_LIMIT)));

  p_fault_seen_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_en && (mem_addr <= AW'(LOW_LIMIT))) |-> low_fault);
endmodule

bind stk_engine stk_engine_chk #(.DATA_W(DATA_W), .LOW_LIMIT(LOW_LIMIT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .busy         (busy),
  .spr_wr_hi    (spr_wr_hi),
  .spr_wr_lo    (spr_wr_lo),
  .spr_wdata    (spr_wdata),
  .spr_hi       (spr_hi),
  .spr_lo       (spr_lo),
  .mem_en       (mem_en),
  .mem_addr     (mem_addr),
  .rsp_byte_vld (rsp_byte_vld),
  .rsp_addr_vld (rsp_addr_vld),
  .low_fault    (low_fault)
);

// File: tb/test_stk_engine.sv
module test_stk_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_D      = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [7:0]  req_byte = 8'd0;
  logic [15:0] req_ret = 16'd0;
  logic        busy;
  logic        spr_wr_hi = 1'b0, spr_wr_lo = 1'b0;
  logic [7:0]  spr_wdata = 8'd0;
  logic [7:0]  spr_hi, spr_lo;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'd0;
  logic        rsp_byte_vld, rsp_addr_vld, low_fault;
  logic [7:0]  rsp_byte;
  logic [15:0] rsp_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_engine i_stk_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_byte(req_byte), .req_ret(req_ret), .busy(busy),
    .spr_wr_hi(spr_wr_hi), .spr_wr_lo(spr_wr_lo), .spr_wdata(spr_wdata),
    .spr_hi(spr_hi), .spr_lo(spr_lo), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_byte_vld(rsp_byte_vld), .rsp_byte(rsp_byte),
    .rsp_addr_vld(rsp_addr_vld), .rsp_addr(rsp_addr), .low_fault(low_fault)
  );

  // synchronous memory model: read data one cycle after the access
  logic [7:0] mem_model [0:MEM_D-1];
  always_ff @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_model[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= mem_model[mem_addr[11:0]];
    end
  end

  logic [7:0]  ref_mem [0:MEM_D-1];
  logic [15:0] exp_sp;
  int          depth = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  function automatic bit is_low(input logic [15:0] a);
    return a <= 16'h00FF;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic chk_sp(input string rq);
    chk({spr_hi, spr_lo} == exp_sp, rq, {spr_hi, spr_lo}, exp_sp);
  endtask

  task automatic chk_acc(input string rq, input bit we, input logic [15:0] a, input logic [7:0] d);
    chk(mem_en && (mem_we == we), rq, {mem_en, mem_we}, {1'b1, we});
    chk(mem_addr == a, rq, mem_addr, a);
    if (we) chk(mem_wdata == d, rq, mem_wdata, d);
    chk(low_fault == is_low(a), "R9", low_fault, is_low(a));
  endtask

  // all operation tasks start and end at a falling edge
  task automatic issue(input logic [1:0] op, input logic [7:0] b, input logic [15:0] a);
    req_valid = 1'b1; req_op = op; req_byte = b; req_ret = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic sw_set(input logic [15:0] v);
    spr_wr_hi = 1'b1; spr_wr_lo = 1'b1; spr_wdata = v[15:8];
    @(negedge clk);
    spr_wr_hi = 1'b0;
    spr_wdata = v[7:0];
    @(negedge clk);
    spr_wr_lo = 1'b0;
    exp_sp = v;
  endtask

  task automatic op_push(input logic [7:0] b);
    logic [15:0] s = exp_sp;
    issue(2'd0, b, 16'd0);
    chk_acc("R2", 1'b1, s, b);
    chk(!busy, "R2", busy, 0);
    ref_mem[s[11:0]] = b;
    exp_sp = s - 16'd1;
    depth++;
    chk_sp("R2");
  endtask

  task automatic op_pop();
    logic [15:0] s = exp_sp + 16'd1;
    logic [7:0]  e = ref_mem[s[11:0]];
    issue(2'd1, 8'd0, 16'd0);
    chk_acc("R3", 1'b0, s, 8'd0);
    exp_sp = s;
    depth--;
    chk_sp("R3");
    @(negedge clk);
    @(negedge clk);
    chk(rsp_byte_vld && rsp_byte == e, "R3", {rsp_byte_vld, rsp_byte}, {1'b1, e});
  endtask

  task automatic op_call(input logic [15:0] a);
    logic [15:0] s = exp_sp;
    issue(2'd2, 8'd0, a);
    chk_acc("R4", 1'b1, s, a[7:0]);
    chk(busy, "R4", busy, 1);
    @(negedge clk);
    chk_acc("R4", 1'b1, s - 16'd1, a[15:8]);
    chk(!busy, "R4", busy, 0);
    ref_mem[s[11:0]] = a[7:0];
    ref_mem[(s - 16'd1) & 16'h0FFF] = a[15:8];
    exp_sp = s - 16'd2;
    depth += 2;
    chk_sp("R4");
  endtask

  task automatic op_ret();
    logic [15:0] s = exp_sp;
    logic [15:0] e = {ref_mem[(s + 16'd1) & 16'h0FFF], ref_mem[(s + 16'd2) & 16'h0FFF]};
    issue(2'd3, 8'd0, 16'd0);
    chk_acc("R5", 1'b0, s + 16'd1, 8'd0);
    chk(busy, "R5", busy, 1);
    @(negedge clk);
    chk_acc("R5", 1'b0, s + 16'd2, 8'd0);
    exp_sp = s + 16'd2;
    depth -= 2;
    chk_sp("R5");
    @(negedge clk);
    @(negedge clk);
    chk(rsp_addr_vld && rsp_addr == e, "R5", {rsp_addr_vld, rsp_addr}, {1'b1, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < MEM_D; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({spr_hi, spr_lo} == 16'h0000, "R1", {spr_hi, spr_lo}, 0);
    chk(!busy && !mem_en, "R1", {busy, mem_en}, 0);
    chk(!rsp_byte_vld && !rsp_addr_vld, "R1", {rsp_byte_vld, rsp_addr_vld}, 0);

    // R6 byte-wise software access
    spr_wr_hi = 1'b1; spr_wdata = 8'h12;
    @(negedge clk);
    spr_wr_hi = 1'b0;
    chk(spr_hi == 8'h12 && spr_lo == 8'h00, "R6", {spr_hi, spr_lo}, 16'h1200);
    spr_wr_lo = 1'b1; spr_wdata = 8'h34;
    @(negedge clk);
    spr_wr_lo = 1'b0;
    chk(spr_hi == 8'h12 && spr_lo == 8'h34, "R6", {spr_hi, spr_lo}, 16'h1234);
    spr_wr_hi = 1'b1; spr_wr_lo = 1'b1; spr_wdata = 8'h08;
    @(negedge clk);
    spr_wr_hi = 1'b0; spr_wr_lo = 1'b0;
    chk({spr_hi, spr_lo} == 16'h0808, "R6", {spr_hi, spr_lo}, 16'h0808);

    // R2 / R3 byte stack
    sw_set(16'h0800);
    op_push(8'hA5);
    op_push(8'h3C);
    op_pop();
    op_pop();
    // R4 / R5 address stack
    op_call(16'h1234);
    op_ret();

    // R7 software write wins over a same-cycle push
    req_valid = 1'b1; req_op = 2'd0; req_byte = 8'h99;
    spr_wr_lo = 1'b1; spr_wdata = 8'h40;
    @(negedge clk);
    req_valid = 1'b0; spr_wr_lo = 1'b0;
    exp_sp = 16'h0840;
    chk(!mem_en, "R7", mem_en, 0);
    chk_sp("R7");

    // R8 request during busy is dropped
    issue(2'd2, 8'd0, 16'hBEEF);
    chk_acc("R8", 1'b1, 16'h0840, 8'hEF);
    req_valid = 1'b1; req_op = 2'd0; req_byte = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    chk_acc("R8", 1'b1, 16'h083F, 8'hBE);
    @(negedge clk);
    chk(!mem_en, "R8", mem_en, 0);
    exp_sp = 16'h083E;
    chk_sp("R8");
    ref_mem[12'h840] = 8'hEF;
    ref_mem[12'h83F] = 8'hBE;
    depth = 2;
    op_ret();

    // R10 back-to-back byte pushes and pops
    sw_set(16'h0900);
    req_valid = 1'b1; req_op = 2'd0; req_byte = 8'h11;
    @(negedge clk);
    chk_acc("R10", 1'b1, 16'h0900, 8'h11);
    req_byte = 8'h22;
    @(negedge clk);
    chk_acc("R10", 1'b1, 16'h08FF, 8'h22);
    req_op = 2'd1;
    @(negedge clk);
    chk_acc("R10", 1'b0, 16'h08FF, 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
    chk_acc("R10", 1'b0, 16'h0900, 8'h00);
    @(negedge clk);
    chk(rsp_byte_vld && rsp_byte == 8'h22, "R10", {rsp_byte_vld, rsp_byte}, 9'h122);
    @(negedge clk);
    chk(rsp_byte_vld && rsp_byte == 8'h11, "R10", {rsp_byte_vld, rsp_byte}, 9'h111);
    exp_sp = 16'h0900;
    chk_sp("R10");

    // R9 low-page boundary
    sw_set(16'h0100);
    depth = 0;
    op_push(8'h5A);
    op_push(8'hC3);
    op_pop();
    op_pop();

    // random mix around a mid-memory base
    sw_set(16'h0800);
    depth = 0;
    for (int i = 0; i < 400; i++) begin
      int unsigned r = $urandom % 4;
      if (depth > 600) r = 3;
      if (r == 1 && depth < 1) r = 0;
      if (r == 3 && depth < 2) r = 2;
      case (r)
        0: op_push(8'($urandom));
        1: op_pop();
        2: op_call(16'($urandom));
        default: op_ret();
      endcase
      if (($urandom % 3) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule